// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides a 32-bit dividend by a 32-bit divisor over many clock cycles. Each cycle it produces one quotient bit. It uses one subtractor and a single register pair holding the partial remainder and the quotient. The two registers shift left together. The quotient bit that is produced enters from the right.

A mode input selects unsigned or two's-complement signed operation. In signed mode, negative operands are turned into magnitudes in one extra cycle before the loop. The results are then corrected in one extra cycle after the loop. The quotient is negative when exactly one operand is negative. The remainder always carries the sign of the dividend.

The quotient is returned on `lo_o` and the remainder on `hi_o`. Both are held until the next operation completes. A one-cycle `done_o` pulse marks the cycle in which new results first appear.

Top module: `seq_divider`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `busy_o`, `done_o`, `hi_o` and `lo_o` are all zero. A reset during an operation abandons that operation.
- R2: In unsigned mode (`signed_i`=0), `lo_o` = floor(dividend/divisor) and `hi_o` = dividend mod divisor. This holds for every nonzero divisor, including divisors whose bit 31 is set.
- R3: A start pulse seen while idle is accepted at that clock edge. In unsigned mode, `busy_o` is then high for exactly 32 cycles. `done_o` is high in the cycle after the last busy cycle.
- R4: In signed mode (`signed_i`=1), the operands are read as two's complement. The quotient magnitude and the remainder magnitude come from unsigned division of the operand magnitudes. The quotient is negated when the operand signs differ. The remainder is negated when the dividend is negative. For example, 17/3 = (5,2), 17/-3 = (-5,2), -17/3 = (-5,-2) and -17/-3 = (5,-2).
- R5: In signed mode, `busy_o` is high for exactly 34 cycles after the accepting edge.
- R6: A start pulse seen while `busy_o` is high is ignored. The running operation keeps its operands, its result and its latency.
- R7: `hi_o` and `lo_o` change only in a cycle where `done_o` is high. Otherwise they hold their last value.
- R8: A zero divisor raises no error. The operation still completes with the normal latency of its mode, and its result values are unspecified.
- R9: The signed division -2^31 / -1 wraps, giving `lo_o` = 0x80000000 and `hi_o` = 0.
- R10: `done_o` is high for exactly one cycle per operation, and never while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse. It is accepted only while idle. |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned operands |
| dividend_i | input | 32 | Dividend, sampled at the accepting edge |
| divisor_i | input | 32 | Divisor, sampled at the accepting edge |
| busy_o | output | 1 | High while an operation is in progress |
| done_o | output | 1 | One-cycle pulse when new results are valid |
| hi_o | output | 32 | Remainder |
| lo_o | output | 32 | Quotient |

## Verification
The unsigned vectors cover several cases:
- Ordinary small quotients, and a dividend smaller than its divisor.
- A divisor of one.
- Divisors with bit 31 set. These separate a correct 33-bit comparison from one that drops the shifted-out remainder bit.

The signed vectors cover all four sign combinations of 17 and 3. They separate the XOR quotient sign from the dividend-following remainder sign. Further signed cases are a zero dividend over a negative divisor, a most-negative dividend, and the -2^31 / -1 wrap.

Directed runs cover the remaining behaviour:
- A start pulse issued mid-operation.
- A zero divisor, checked only for completion.
- Result holding after `done_o`.
- A reset issued during a busy period.

// File: rtl/div_pkg.sv
package div_pkg;

    // Controller phases of one division
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PREP = 2'd1,
        PH_LOOP = 2'd2,
        PH_FIX  = 2'd3
    } div_phase_e;

endpackage

// File: rtl/div_magnitude.sv
// Converts a possibly negative operand into its magnitude when enabled.
module div_magnitude #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] value_i,
    input  logic             en_i,
    output logic [WIDTH-1:0] mag_o,
    output logic             neg_o
);
    always_comb begin
        neg_o = en_i & value_i[WIDTH-1];
        mag_o = neg_o ? (~value_i + WIDTH'(1)) : value_i;
    end
endmodule

// File: rtl/div_restore_step.sv
// One radix-2 restoring step on the left-shifting remainder/quotient pair.
module div_restore_step #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] rem_i,
    input  logic [WIDTH-1:0] quo_i,
    input  logic [WIDTH-1:0] dvs_i,
    output logic [WIDTH-1:0] rem_o,
    output logic [WIDTH-1:0] quo_o
);
    localparam int EXT_W = WIDTH + 1;

    logic [EXT_W-1:0] shifted;
    logic [EXT_W-1:0] trial;
    logic             fits;

    always_comb begin
        // the remainder MSB leaving the register stays in the comparison
        shifted = {rem_i, quo_i[WIDTH-1]};
        trial   = shifted - {1'b0, dvs_i};
        fits    = ~trial[EXT_W-1];
        rem_o   = fits ? trial[WIDTH-1:0] : shifted[WIDTH-1:0];
        quo_o   = {quo_i[WIDTH-2:0], fits};
    end
endmodule

// File: rtl/div_negate.sv
// Conditional two's-complement negation of a result word.
module div_negate #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] value_i,
    input  logic             en_i,
    output logic [WIDTH-1:0] res_o
);
    always_comb begin
        res_o = en_i ? (~value_i + WIDTH'(1)) : value_i;
    end
endmodule

// File: rtl/seq_divider.sv
module seq_divider
    import div_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             signed_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o
);
    localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

    typedef struct packed {
        div_phase_e       phase;
        logic [WIDTH-1:0] rem;
        logic [WIDTH-1:0] quo;
        logic [WIDTH-1:0] dvs;
        logic [CNT_W-1:0] step;
        logic             sgn;
        logic             neg_quo;
        logic             neg_rem;
        logic             done;
        logic [WIDTH-1:0] hi;
        logic [WIDTH-1:0] lo;
    } div_state_t;

    div_state_t st_d, st_q;

    // operand magnitudes, used in the preparation phase
    logic [WIDTH-1:0] dvd_mag, dvs_mag;
    logic             dvd_neg, dvs_neg;

    div_magnitude #(.WIDTH(WIDTH)) u_mag_dvd (
        .value_i (st_q.quo),
        .en_i    (st_q.sgn),
        .mag_o   (dvd_mag),
        .neg_o   (dvd_neg)
    );

    div_magnitude #(.WIDTH(WIDTH)) u_mag_dvs (
        .value_i (st_q.dvs),
        .en_i    (st_q.sgn),
        .mag_o   (dvs_mag),
        .neg_o   (dvs_neg)
    );

    // one quotient bit per cycle
    logic [WIDTH-1:0] step_rem, step_quo;

    div_restore_step #(.WIDTH(WIDTH)) u_step (
        .rem_i (st_q.rem),
        .quo_i (st_q.quo),
        .dvs_i (st_q.dvs),
        .rem_o (step_rem),
        .quo_o (step_quo)
    );

    // sign correction of the finished results
    logic [WIDTH-1:0] fix_rem, fix_quo;

    div_negate #(.WIDTH(WIDTH)) u_neg_rem (
        .value_i (st_q.rem),
        .en_i    (st_q.neg_rem),
        .res_o   (fix_rem)
    );

    div_negate #(.WIDTH(WIDTH)) u_neg_quo (
        .value_i (st_q.quo),
        .en_i    (st_q.neg_quo),
        .res_o   (fix_quo)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.sgn     = signed_i;
                    st_d.quo     = dividend_i;
                    st_d.dvs     = divisor_i;
                    st_d.rem     = '0;
                    st_d.step    = '0;
                    st_d.neg_quo = 1'b0;
                    st_d.neg_rem = 1'b0;
                    st_d.phase   = signed_i ? PH_PREP : PH_LOOP;
                end
            end
            PH_PREP: begin
                st_d.quo     = dvd_mag;
                st_d.dvs     = dvs_mag;
                st_d.neg_quo = dvd_neg ^ dvs_neg;
                st_d.neg_rem = dvd_neg;
                st_d.phase   = PH_LOOP;
            end
            PH_LOOP: begin
                st_d.rem  = step_rem;
                st_d.quo  = step_quo;
                st_d.step = st_q.step + CNT_W'(1);
                if (st_q.step == LAST_STEP) begin
                    if (st_q.sgn) begin
                        st_d.phase = PH_FIX;
                    end else begin
                        st_d.hi    = step_rem;
                        st_d.lo    = step_quo;
                        st_d.done  = 1'b1;
                        st_d.phase = PH_IDLE;
                    end
                end
            end
            PH_FIX: begin
                st_d.hi    = fix_rem;
                st_d.lo    = fix_quo;
                st_d.done  = 1'b1;
                st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = (st_q.phase != PH_IDLE);
    assign done_o = st_q.done;
    assign hi_o   = st_q.hi;
    assign lo_o   = st_q.lo;

endmodule

// File: rtl/seq_divider_chk.sv
module seq_divider_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             signed_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [WIDTH-1:0] hi_o,
    input logic [WIDTH-1:0] lo_o
);
    localparam int LEN_W = $clog2(WIDTH + 3) + 1;

    logic [LEN_W-1:0] run_len;
    logic             run_sgn;

    // busy cycles since the last accepted start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
            run_sgn <= 1'b0;
        end else if (start_i && !busy_o) begin
            run_len <= '0;
            run_sgn <= signed_i;
        end else if (busy_o) begin
            run_len <= run_len + LEN_W'(1);
        end
    end

    // R3
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> busy_o);

    // R5
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (run_len == (run_sgn ? LEN_W'(WIDTH + 2) : LEN_W'(WIDTH))));

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(hi_o) && $stable(lo_o)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o);

endmodule

bind seq_divider seq_divider_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .signed_i (signed_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .hi_o     (hi_o),
    .lo_o     (lo_o)
);

// File: tb/tb_seq_divider.sv
`timescale 1ns/1ps
module tb_seq_divider;
    localparam int W  = 32;
    localparam int NV = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         signed_i = 1'b0;
    logic [W-1:0] dividend_i = '0;
    logic [W-1:0] divisor_i = '0;
    logic         busy_o, done_o;
    logic [W-1:0] hi_o, lo_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    seq_divider #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
        .dividend_i(dividend_i), .divisor_i(divisor_i),
        .busy_o(busy_o), .done_o(done_o), .hi_o(hi_o), .lo_o(lo_o)
    );

    // {signed, dividend, divisor, quotient, remainder}
    localparam logic [128:0] VEC [NV] = '{
        {1'b0, 32'd217,        32'd11,         32'd19,         32'd8},
        {1'b0, 32'd14,         32'd3,          32'd4,          32'd2},
        {1'b0, 32'd5,          32'd7,          32'd0,          32'd5},
        {1'b0, 32'hFFFFFFFF,   32'd1,          32'hFFFFFFFF,   32'd0},
        {1'b0, 32'hFFFFFFFF,   32'h80000001,   32'd1,          32'h7FFFFFFE},
        {1'b0, 32'h80000000,   32'h80000000,   32'd1,          32'd0},
        {1'b0, 32'd1000000007, 32'hF0000000,   32'd0,          32'd1000000007},
        {1'b0, 32'hFFFFFFFE,   32'hFFFFFFFF,   32'd0,          32'hFFFFFFFE},
        {1'b1, 32'd17,         32'd3,          32'd5,          32'd2},
        {1'b1, 32'd17,         32'(-3),        32'(-5),        32'd2},
        {1'b1, 32'(-17),       32'd3,          32'(-5),        32'(-2)},
        {1'b1, 32'(-17),       32'(-3),        32'd5,          32'(-2)},
        {1'b1, 32'(-7),        32'd7,          32'(-1),        32'd0},
        {1'b1, 32'd0,          32'(-5),        32'd0,          32'd0},
        {1'b1, 32'h80000000,   32'd3,          32'(-715827882), 32'(-2)},
        {1'b1, 32'd100,        32'h80000000,   32'd0,          32'd100},
        {1'b1, 32'h80000000,   32'hFFFFFFFF,   32'h80000000,   32'd0},
        {1'b1, 32'd1000,       32'(-1000),     32'(-1),        32'd0}
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one operation; return busy count and results at the done cycle
    task automatic run_op(input logic sm, input logic [W-1:0] a, input logic [W-1:0] b,
                          input int mid_start, output int lat,
                          output logic [W-1:0] q, output logic [W-1:0] r);
        @(negedge clk);
        signed_i = sm; dividend_i = a; divisor_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 100) begin
            if (busy_o) lat++;
            if (mid_start > 0 && lat == mid_start) begin
                signed_i = ~sm; dividend_i = 32'd99; divisor_i = 32'd2; start_i = 1'b1;
            end
            @(negedge clk);
            start_i = 1'b0;
        end
        q = lo_o; r = hi_o;
    endtask

    initial begin
        int lat;
        logic [W-1:0] q, r;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", W'(busy_o), 0);
        check("R1 done", W'(done_o), 0);
        check("R1 hi", hi_o, 0);
        check("R1 lo", lo_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after release", W'(busy_o), 0);

        for (int i = 0; i < NV; i++) begin
            logic sm;
            sm = VEC[i][128];
            run_op(sm, VEC[i][127:96], VEC[i][95:64], 0, lat, q, r);
            check(sm ? "R4 quotient" : "R2 quotient", q, VEC[i][63:32]);
            check(sm ? "R4 remainder" : "R2 remainder", r, VEC[i][31:0]);
            check(sm ? "R5 latency" : "R3 latency", W'(lat), sm ? W'(W + 2) : W'(W));
            @(negedge clk);
            check("R10 done one cycle", W'(done_o), 0);
            check("R7 hold lo", lo_o, VEC[i][63:32]);
            check("R7 hold hi", hi_o, VEC[i][31:0]);
        end
        // R9 explicit wrap case
        run_op(1'b1, 32'h80000000, 32'hFFFFFFFF, 0, lat, q, r);
        check("R9 wrap quotient", q, 32'h80000000);
        check("R9 wrap remainder", r, 32'd0);

        // R6 start while busy ignored (unsigned, then signed)
        run_op(1'b0, 32'd1000, 32'd7, 5, lat, q, r);
        check("R6 quotient", q, 32'd142);
        check("R6 remainder", r, 32'd6);
        check("R6 latency", W'(lat), W'(W));
        run_op(1'b1, 32'(-1000), 32'd7, 20, lat, q, r);
        check("R6 signed quotient", q, 32'(-142));
        check("R6 signed remainder", r, 32'(-6));
        check("R6 signed latency", W'(lat), W'(W + 2));

        // R8 divide by zero completes normally
        run_op(1'b0, 32'd1234, 32'd0, 0, lat, q, r);
        check("R8 unsigned latency", W'(lat), W'(W));
        run_op(1'b1, 32'(-1234), 32'd0, 0, lat, q, r);
        check("R8 signed latency", W'(lat), W'(W + 2));

        // R7 results hold across idle cycles
        run_op(1'b0, 32'd50, 32'd8, 0, lat, q, r);
        repeat (10) @(negedge clk);
        check("R7 idle hold lo", lo_o, 32'd6);
        check("R7 idle hold hi", hi_o, 32'd2);

        // R1 reset mid-operation abandons it
        @(negedge clk);
        signed_i = 1'b0; dividend_i = 32'd77; divisor_i = 32'd5; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 busy in reset", W'(busy_o), 0);
        check("R1 lo in reset", lo_o, 0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        check("R1 no done after abort", W'(done_o), 0);
        check("R1 busy after abort", W'(busy_o), 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule